// File: doc/BRIEF.md
# Vectored Interrupt Message Controller

This block gathers 64 wired interrupt lines and turns each one that is pending, unmasked and allowed to send into a single outbound message. The message carries an 8-bit vector and an 8-bit route byte, and both are programmed per line. Each line goes through a two-flop synchroniser. It can then be sensed as a level or as an edge, with either sense of polarity. Edge events are held in a pending latch until the message leaves or firmware discards them.

Firmware sets the block up through a word-wide register port with byte enables. Reads return one cycle after the request. Every per-line single-bit control lives in a bank of two 32-bit words: line n sits in the word at bank base plus 4*(n/32), at bit n%32. The per-line bytes are packed four to a word, so line n sits in byte lane n%4. When several lines are eligible at once, the lowest-numbered one is sent first. Messages leave on a valid/ready handshake.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset every line is masked and the mask bank reads all ones. All other banks, route bytes and vector bytes read zero, no edge is pending, and msg_valid is low.
- R2: The read-only identification word at byte offset 0x4 holds the line count minus one (63) in bits 23:16, and zero in all other bits. These are bits 55:48 of a 64-bit ID at offset 0. The word at offset 0x0 reads zero, and writes to either word have no effect.
- R3: The control banks can be read and written, and only the byte lanes whose reg_be bit is set are written. The banks are at these offsets: message-enable 0x40, trigger 0x60 (1 = edge), polarity 0x3E0 (1 = falling edge or active-low), mask 0x20 (1 = masked), and storage-only auto banks 0xC0 and 0xE0.
- R4: Route byte n is at byte offset 0x100+n and vector byte n is at 0x200+n. Each one can be written on its own through its byte enable.
- R5: A level line whose polarity-adjusted input is active, and which is unmasked and enabled, raises msg_valid on the third rising clock edge after the input changes.
- R6: An edge line latches a pending event when its selected edge appears on the synchronised input, and raises msg_valid on the fourth rising edge after the input changes. It sends exactly one message for each edge.
- R7: A masked line, or a line whose message-enable bit is 0, sends nothing. A pending edge survives while its line is masked and is sent after the line is unmasked. Once a line is both unmasked and enabled, msg_valid rises on the edge after the register write.
- R8: Writing 1 to a bit of the clear bank (0x80) discards that line's pending edge and leaves the other lines unchanged. The clear bank reads zero.
- R9: When several lines are eligible, the lowest-numbered line is sent first. The next line follows one cycle after the handshake.
- R10: A level line that stays active after its message is sent is not sent again until it has gone inactive, or until it has been masked and then unmasked.
- R11: While msg_valid is high and msg_ready is low, msg_valid, msg_vector and msg_route hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Byte address (word aligned) |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte enables for writes |
| reg_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_in | input | 64 | Asynchronous interrupt lines |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_vector | output | 8 | Vector of the line being sent |
| msg_route | output | 8 | Route byte of the line being sent |

## Verification
Each result has a fixed latency. Counted in rising edges after a stimulus applied on a falling edge:
- Read data is due after one edge.
- A level message is due after three edges: two synchroniser flops, then the output register.
- An edge message is due after four edges, because the pending latch adds one.
- A mask or enable write lets a message out on the edge after the write edge.
- After a handshake, the next message is due one edge after valid drops.

The bench drives every input on falling edges and counts exactly that many rising edges before it samples on the next falling edge. Where a requirement says nothing happens, it also checks one edge earlier, or several edges later.

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl #(
  parameter int NUM_LINES = 64,
  parameter int AW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_en,
  input  logic                 reg_we,
  input  logic [AW-1:0]        reg_addr,
  input  logic [31:0]          reg_wdata,
  input  logic [3:0]           reg_be,
  output logic [31:0]          reg_rdata,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [7:0]           msg_vector,
  output logic [7:0]           msg_route
);
  localparam int NW = NUM_LINES / 32;
  localparam int LW = $clog2(NUM_LINES);
  localparam int OFF_ID_HI = 32'h004;
  localparam int OFF_MASK  = 32'h020;
  localparam int OFF_EN    = 32'h040;
  localparam int OFF_TRIG  = 32'h060;
  localparam int OFF_CLR   = 32'h080;
  localparam int OFF_AUX0  = 32'h0C0;
  localparam int OFF_AUX1  = 32'h0E0;
  localparam int OFF_ROUTE = 32'h100;
  localparam int OFF_VEC   = 32'h200;
  localparam int OFF_POL   = 32'h3E0;
  localparam logic [7:0] LINES_M1 = 8'(NUM_LINES - 1);

  function automatic logic [31:0] lane_merge(input logic [31:0] old_w, input logic [31:0] new_w,
                                             input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? new_w[b*8 +: 8] : old_w[b*8 +: 8];
    return r;
  endfunction

  logic [NUM_LINES-1:0] mask_q, en_q, trig_q, pol_q, aux0_q, aux1_q;
  logic [7:0] route_q [NUM_LINES];
  logic [7:0] vec_q   [NUM_LINES];

  logic [NUM_LINES-1:0] sync1_q, sync2_q, act_q, pend_q, lvl_done_q;
  logic [NUM_LINES-1:0] active, rise, clr, sent, req;
  logic [AW-1:0] wa;
  logic wr, rd;
  logic [LW-1:0] win, out_line_q;
  logic any_req;
  logic [31:0] rd_mux;

  assign wa = {reg_addr[AW-1:2], 2'b00};
  assign wr = reg_en & reg_we;
  assign rd = reg_en & ~reg_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      en_q   <= '0;
      trig_q <= '0;
      pol_q  <= '0;
      aux0_q <= '0;
      aux1_q <= '0;
    end else if (wr) begin
      for (int w = 0; w < NW; w++) begin
        if (wa == AW'(OFF_MASK + 4*w)) mask_q[w*32 +: 32] <= lane_merge(mask_q[w*32 +: 32], reg_wdata, reg_be);
        if (wa == AW'(OFF_EN   + 4*w)) en_q[w*32 +: 32]   <= lane_merge(en_q[w*32 +: 32], reg_wdata, reg_be);
        if (wa == AW'(OFF_TRIG + 4*w)) trig_q[w*32 +: 32] <= lane_merge(trig_q[w*32 +: 32], reg_wdata, reg_be);
        if (wa == AW'(OFF_POL  + 4*w)) pol_q[w*32 +: 32]  <= lane_merge(pol_q[w*32 +: 32], reg_wdata, reg_be);
        if (wa == AW'(OFF_AUX0 + 4*w)) aux0_q[w*32 +: 32] <= lane_merge(aux0_q[w*32 +: 32], reg_wdata, reg_be);
        if (wa == AW'(OFF_AUX1 + 4*w)) aux1_q[w*32 +: 32] <= lane_merge(aux1_q[w*32 +: 32], reg_wdata, reg_be);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NUM_LINES; n++) begin
        route_q[n] <= '0;
        vec_q[n]   <= '0;
      end
    end else if (wr) begin
      for (int n = 0; n < NUM_LINES; n++) begin
        if (wa == AW'(OFF_ROUTE + (n/4)*4) && reg_be[n%4]) route_q[n] <= reg_wdata[(n%4)*8 +: 8];
        if (wa == AW'(OFF_VEC + (n/4)*4) && reg_be[n%4])   vec_q[n]   <= reg_wdata[(n%4)*8 +: 8];
      end
    end
  end

  always_comb begin
    clr = '0;
    for (int w = 0; w < NW; w++)
      if (wr && wa == AW'(OFF_CLR + 4*w)) clr[w*32 +: 32] = lane_merge(32'h0, reg_wdata, reg_be);
  end

  assign active = sync2_q ^ pol_q;
  assign rise   = active & ~act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      act_q   <= '0;
    end else begin
      sync1_q <= irq_in;
      sync2_q <= sync1_q;
      act_q   <= active;
    end
  end

  always_comb begin
    sent = '0;
    if (msg_valid && msg_ready) sent[out_line_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      lvl_done_q <= '0;
    end else begin
      pend_q     <= (pend_q & ~clr & ~sent) | (rise & trig_q);
      lvl_done_q <= (lvl_done_q | (sent & ~trig_q)) & active & ~mask_q;
    end
  end

  assign req = ((trig_q & pend_q) | (~trig_q & active & ~lvl_done_q)) & ~mask_q & en_q;

  always_comb begin
    win = '0;
    any_req = 1'b0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (req[i]) begin
        win = LW'(i);
        any_req = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid  <= 1'b0;
      out_line_q <= '0;
      msg_vector <= '0;
      msg_route  <= '0;
    end else if (!msg_valid) begin
      if (any_req) begin
        msg_valid  <= 1'b1;
        out_line_q <= win;
        msg_vector <= vec_q[win];
        msg_route  <= route_q[win];
      end
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (wa == AW'(OFF_ID_HI)) rd_mux = {8'h00, LINES_M1, 16'h0000};
    for (int w = 0; w < NW; w++) begin
      if (wa == AW'(OFF_MASK + 4*w)) rd_mux = mask_q[w*32 +: 32];
      if (wa == AW'(OFF_EN   + 4*w)) rd_mux = en_q[w*32 +: 32];
      if (wa == AW'(OFF_TRIG + 4*w)) rd_mux = trig_q[w*32 +: 32];
      if (wa == AW'(OFF_POL  + 4*w)) rd_mux = pol_q[w*32 +: 32];
      if (wa == AW'(OFF_AUX0 + 4*w)) rd_mux = aux0_q[w*32 +: 32];
      if (wa == AW'(OFF_AUX1 + 4*w)) rd_mux = aux1_q[w*32 +: 32];
    end
    for (int n = 0; n < NUM_LINES; n++) begin
      if (wa == AW'(OFF_ROUTE + (n/4)*4)) rd_mux[(n%4)*8 +: 8] = route_q[n];
      if (wa == AW'(OFF_VEC + (n/4)*4))   rd_mux[(n%4)*8 +: 8] = vec_q[n];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_msg_ctrl_chk.sv
module irq_msg_ctrl_chk #(
  parameter int NUM_LINES = 64,
  parameter int AW = 10
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_en,
  input logic                 reg_we,
  input logic [AW-1:0]        reg_addr,
  input logic [31:0]          reg_rdata,
  input logic                 msg_valid,
  input logic                 msg_ready,
  input logic [7:0]           msg_vector,
  input logic [7:0]           msg_route,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] en_q
);
  p_reset_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (mask_q == '1 && !msg_valid));

  p_id_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_we && reg_addr == AW'(4)) |=> (reg_rdata == {8'h00, 8'(NUM_LINES - 1), 16'h0000}));

  p_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> ($past(en_q & ~mask_q) != '0));

  p_clear_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !reg_we && reg_addr == AW'(32'h80)) |=> (reg_rdata == 32'h0));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_route)));
endmodule

bind irq_msg_ctrl irq_msg_ctrl_chk #(.NUM_LINES(NUM_LINES), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_route(msg_route), .mask_q(mask_q), .en_q(en_q)
);

// File: tb/irq_msg_ctrl_tb_top.sv
module irq_msg_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [9:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0] reg_be = '0;
  logic [31:0] reg_rdata;
  logic [63:0] irq_in = '0;
  logic msg_valid;
  logic msg_ready = 1'b1;
  logic [7:0] msg_vector, msg_route;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  irq_msg_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_route(msg_route)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic [3:0] be);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_in = '0; msg_ready = 1'b1;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic t_registers();
    logic [31:0] d;
    do_reset();
    chk("R1 msg_valid after reset", 32'(msg_valid), 32'h0);
    rd(10'h020, d); chk("R1 mask word0", d, 32'hFFFFFFFF);
    rd(10'h024, d); chk("R1 mask word1", d, 32'hFFFFFFFF);
    rd(10'h064, d); chk("R1 trigger word1", d, 32'h0);
    rd(10'h3E0, d); chk("R1 polarity word0", d, 32'h0);
    rd(10'h23C, d); chk("R1 vector bytes 60..63", d, 32'h0);
    rd(10'h004, d); chk("R2 id word", d, 32'h003F0000);
    rd(10'h000, d); chk("R2 id low word", d, 32'h0);
    wr(10'h004, 32'hFFFFFFFF, 4'hF);
    rd(10'h004, d); chk("R2 id after write", d, 32'h003F0000);
    wr(10'h0C4, 32'hA5A5A5A5, 4'b0101);
    rd(10'h0C4, d); chk("R3 aux0 partial lanes", d, 32'h00A500A5);
    wr(10'h0E0, 32'h12345678, 4'hF);
    rd(10'h0E0, d); chk("R3 aux1 full word", d, 32'h12345678);
    wr(10'h104, 32'h11223344, 4'hF);
    wr(10'h104, 32'hFFFFFFFF, 4'b0100);
    rd(10'h104, d); chk("R4 route byte 6 alone", d, 32'h11FF3344);
    wr(10'h21C, 32'h0000C300, 4'b0010);
    rd(10'h21C, d); chk("R4 vector byte 29", d, 32'h0000C300);
  endtask

  task automatic t_level();
    do_reset();
    wr(10'h204, 32'h00005500, 4'b0010);
    wr(10'h104, 32'h00001100, 4'b0010);
    wr(10'h040, 32'h00000020, 4'hF);
    wr(10'h020, ~32'h00000020, 4'hF);
    msg_ready = 1'b0;
    irq_in[5] = 1'b1;
    cyc(2); chk("R5 not yet after 2 edges", 32'(msg_valid), 32'h0);
    cyc(1); chk("R5 valid after 3 edges", 32'(msg_valid), 32'h1);
    chk("R5 vector", 32'(msg_vector), 32'h55);
    chk("R5 route", 32'(msg_route), 32'h11);
    cyc(2); chk("R11 valid held", 32'(msg_valid), 32'h1);
    chk("R11 vector held", 32'(msg_vector), 32'h55);
    msg_ready = 1'b1;
    cyc(1); chk("R11 drop after handshake", 32'(msg_valid), 32'h0);
    cyc(4); chk("R10 no reissue while active", 32'(msg_valid), 32'h0);
    wr(10'h020, 32'hFFFFFFFF, 4'hF);
    wr(10'h020, ~32'h00000020, 4'hF);
    cyc(1); chk("R10 reissue after mask/unmask", 32'(msg_valid), 32'h1);
    cyc(1); chk("R10 sent", 32'(msg_valid), 32'h0);
    irq_in[5] = 1'b0;
    cyc(4); chk("R5 inactive level silent", 32'(msg_valid), 32'h0);
    irq_in[5] = 1'b1;
    cyc(3); chk("R10 reissue after inactive", 32'(msg_valid), 32'h1);
  endtask

  task automatic t_level_low();
    do_reset();
    wr(10'h220, 32'h00005A00, 4'b0010);
    wr(10'h3E4, 32'h00000002, 4'hF);
    wr(10'h044, 32'h00000002, 4'hF);
    wr(10'h024, ~32'h00000002, 4'hF);
    cyc(1); chk("R5 active-low line 33", 32'(msg_valid), 32'h1);
    chk("R5 active-low vector", 32'(msg_vector), 32'h5A);
  endtask

  task automatic t_edge_falling();
    logic [31:0] d;
    do_reset();
    wr(10'h228, 32'h000000A4, 4'b0001);
    wr(10'h128, 32'h00000007, 4'b0001);
    wr(10'h3E4, 32'h00000100, 4'hF);
    wr(10'h064, 32'h00000100, 4'hF);
    irq_in[40] = 1'b1;
    cyc(3);
    wr(10'h084, 32'h00000100, 4'hF);
    rd(10'h084, d); chk("R8 clear bank reads zero", d, 32'h0);
    wr(10'h044, 32'h00000100, 4'hF);
    wr(10'h024, ~32'h00000100, 4'hF);
    cyc(2); chk("R8 cleared edge not sent", 32'(msg_valid), 32'h0);
    irq_in[40] = 1'b0;
    cyc(3); chk("R6 not yet after 3 edges", 32'(msg_valid), 32'h0);
    cyc(1); chk("R6 falling edge sent after 4", 32'(msg_valid), 32'h1);
    chk("R6 vector", 32'(msg_vector), 32'hA4);
    chk("R6 route", 32'(msg_route), 32'h07);
    cyc(4); chk("R6 one message per edge", 32'(msg_valid), 32'h0);
  endtask

  task automatic t_mask_clear();
    do_reset();
    wr(10'h040, 32'h00000044, 4'hF);
    wr(10'h060, 32'h00000014, 4'hF);
    irq_in[2] = 1'b1;
    irq_in[4] = 1'b1;
    cyc(4); chk("R7 masked edge silent", 32'(msg_valid), 32'h0);
    wr(10'h020, ~32'h00000004, 4'hF);
    cyc(1); chk("R7 pending survives mask", 32'(msg_valid), 32'h1);
    cyc(1);
    wr(10'h020, 32'hFFFFFFFF, 4'hF);
    irq_in[2] = 1'b0;
    cyc(3);
    irq_in[2] = 1'b1;
    cyc(4);
    wr(10'h080, 32'h00000004, 4'hF);
    wr(10'h020, ~32'h00000004, 4'hF);
    cyc(2); chk("R8 clear discards edge", 32'(msg_valid), 32'h0);
    wr(10'h020, ~32'h00000014, 4'hF);
    cyc(2); chk("R7 line 4 not enabled", 32'(msg_valid), 32'h0);
    wr(10'h040, 32'h00000054, 4'hF);
    cyc(1); chk("R8 other line kept after clear", 32'(msg_valid), 32'h1);
    irq_in[6] = 1'b1;
    wr(10'h020, ~32'h00000054, 4'hF);
    wr(10'h040, 32'h00000014, 4'hF);
    cyc(4); chk("R7 disabled level silent", 32'(msg_valid), 32'h0);
    wr(10'h040, 32'h00000054, 4'hF);
    cyc(1); chk("R7 enable releases level", 32'(msg_valid), 32'h1);
  endtask

  task automatic t_priority();
    do_reset();
    wr(10'h200, 32'h03000000, 4'b1000);
    wr(10'h208, 32'h00000900, 4'b0010);
    wr(10'h040, 32'h00000208, 4'hF);
    wr(10'h020, ~32'h00000208, 4'hF);
    msg_ready = 1'b0;
    irq_in[9] = 1'b1;
    irq_in[3] = 1'b1;
    cyc(3); chk("R9 first valid", 32'(msg_valid), 32'h1);
    chk("R9 lowest line first", 32'(msg_vector), 32'h03);
    msg_ready = 1'b1;
    cyc(1); chk("R9 gap after handshake", 32'(msg_valid), 32'h0);
    cyc(1); chk("R9 second line valid", 32'(msg_valid), 32'h1);
    chk("R9 second line vector", 32'(msg_vector), 32'h09);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_registers();
    t_level();
    t_level_low();
    t_edge_falling();
    t_mask_clear();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule